// File: doc/BRIEF.md
# Spread-Spectrum Divider Modulation Controller

This block produces a slowly varying signed offset that is added to the feedback divide value of a PLL, so that the output frequency sweeps back and forth and its emitted energy is spread over a band instead of sitting on a single line. The offset follows a triangle: it starts at zero, walks down one unit per step to a programmable lower limit, turns and walks up one unit per step to a programmable upper limit, turns again, and repeats for as long as spreading is enabled.

The lower limit is programmed as a two's-complement field and the upper limit as a plain unsigned count. The step spacing is set by a period field counted in ticks of a fixed time base. A prescaler derived from the system clock produces that time base. A mode input selects down spread, where the triangle is used as it is, or centre spread, where the triangle is shifted by half its span so that it is balanced around zero. The block outputs both the offset and the modulated divide value.

Top module: `ssc_mod_ctrl`

## Requirements
- R1: While reset is held, and in the first cycle after it with down spread selected, `offset_o` is 0 and `n_mod_o` equals `n_base_i`.
- R2: While `en_i` is low, `offset_o` is 0 and the sequence is cleared. After `en_i` rises again, the walk restarts at 0, heading downward.
- R3: While enabled, the offset moves by exactly one step every (`step_per_i`+1)·TICK_DIV clock cycles, counted from the first enabled cycle. It holds its value between steps.
- R4: The lower limit is −M, where M = 2^LIM_W − `dn_lim_i` for a nonzero field and M = 0 for a zero field. With a 4-bit field, 1111 gives −1, 1011 gives −5 and 1000 gives −8.
- R5: In down spread the offset starts at 0 and moves down by 1 per step until it reaches −M. It then moves up by 1 per step until it reaches +`up_lim_i`, then down again, and repeats.
- R6: If both limits are 0, the offset stays at 0. If the lower limit is 0, the first step goes up.
- R7: With `centre_i` = 1, the offset equals the down-spread walk plus floor((M − `up_lim_i`)/2).
- R8: `n_mod_o` = `n_base_i` + sign-extended `offset_o`, taken modulo 2^NDIV_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous reset, active high |
| en_i | input | 1 | Spreading enable |
| centre_i | input | 1 | 1 = centre spread, 0 = down spread |
| up_lim_i | input | LIM_W | Upper limit of the walk, unsigned |
| dn_lim_i | input | LIM_W | Lower limit magnitude, two's complement |
| step_per_i | input | PER_W | Ticks per step, minus one |
| n_base_i | input | NDIV_W | Unmodulated divide value |
| offset_o | output | LIM_W+2 | Signed modulation offset |
| n_mod_o | output | NDIV_W | Modulated divide value |

## Verification
The step-spacing and unit-move properties assume that the limits, the period and the mode change only while `en_i` is low. Changing any of them during a sweep legitimately breaks the gap count and the single-step move. The stimulus respects this: every register value and mode is set with `en_i` low, and `en_i` is raised at a falling edge. As a result, each sweep begins from a cleared sequencer with fixed settings, and the expected offset after k steps follows directly from the triangle rule.

// File: rtl/ssc_mod_ctrl.sv
module ssc_mod_ctrl #(
  parameter int LIM_W    = 4,
  parameter int PER_W    = 6,
  parameter int NDIV_W   = 11,
  parameter int TICK_DIV = 70
) (
  input  logic                    clk_i,
  input  logic                    rst_i,
  input  logic                    en_i,
  input  logic                    centre_i,
  input  logic [LIM_W-1:0]        up_lim_i,
  input  logic [LIM_W-1:0]        dn_lim_i,
  input  logic [PER_W-1:0]        step_per_i,
  input  logic [NDIV_W-1:0]       n_base_i,
  output logic signed [LIM_W+1:0] offset_o,
  output logic [NDIV_W-1:0]       n_mod_o
);
  localparam int OFS_W = LIM_W + 2;
  localparam int PSC_W = $clog2(TICK_DIV + 1);
  localparam logic signed [OFS_W-1:0] ONE = OFS_W'(1);

  logic [PSC_W-1:0]        psc_q;
  logic [PER_W-1:0]        per_q;
  logic signed [OFS_W-1:0] pos_q;
  logic                    rising_q;

  wire tick = (psc_q == PSC_W'(TICK_DIV - 1));
  wire step = tick && (per_q >= step_per_i);

  wire [LIM_W:0] dn_mag = (dn_lim_i == '0) ? '0
                        : (LIM_W+1)'(2**LIM_W) - {1'b0, dn_lim_i};
  wire signed [OFS_W-1:0] lo_lim    = -$signed({1'b0, dn_mag});
  wire signed [OFS_W-1:0] hi_lim    = $signed({2'b00, up_lim_i});
  wire signed [OFS_W-1:0] span_diff = -(lo_lim + hi_lim);
  wire signed [OFS_W-1:0] bias      = span_diff >>> 1;

  always_ff @(posedge clk_i) begin
    if (rst_i || !en_i) begin
      psc_q    <= '0;
      per_q    <= '0;
      pos_q    <= '0;
      rising_q <= 1'b0;
    end else begin
      psc_q <= tick ? '0 : psc_q + PSC_W'(1);
      if (tick) per_q <= step ? '0 : per_q + PER_W'(1);
      if (step) begin
        if (!rising_q) begin
          if (pos_q > lo_lim) pos_q <= pos_q - ONE;
          else if (pos_q < hi_lim) begin
            pos_q    <= pos_q + ONE;
            rising_q <= 1'b1;
          end
        end else begin
          if (pos_q < hi_lim) pos_q <= pos_q + ONE;
          else if (pos_q > lo_lim) begin
            pos_q    <= pos_q - ONE;
            rising_q <= 1'b0;
          end
        end
      end
    end
  end

  assign offset_o = !en_i ? '0 : (centre_i ? pos_q + bias : pos_q);

  wire [NDIV_W-1:0] ofs_ext = NDIV_W'(offset_o);
  assign n_mod_o = n_base_i + ofs_ext;
endmodule

// File: rtl/ssc_mod_ctrl_chk.sv
module ssc_mod_ctrl_chk #(
  parameter int LIM_W    = 4,
  parameter int PER_W    = 6,
  parameter int NDIV_W   = 11,
  parameter int TICK_DIV = 70
) (
  input logic                    clk_i,
  input logic                    rst_i,
  input logic                    en_i,
  input logic                    centre_i,
  input logic [PER_W-1:0]        step_per_i,
  input logic [NDIV_W-1:0]       n_base_i,
  input logic signed [LIM_W+1:0] offset_o,
  input logic [NDIV_W-1:0]       n_mod_o
);
  localparam int OFS_W = LIM_W + 2;
  localparam int CNT_W = $clog2((2**PER_W) * TICK_DIV + 2) + 1;

  logic signed [OFS_W-1:0] prev_q;
  logic [CNT_W-1:0]        gap_q;

  wire chg = (offset_o != prev_q);
  wire [CNT_W-1:0] need = CNT_W'((32'(step_per_i) + 1) * TICK_DIV);
  wire signed [OFS_W:0] move = (OFS_W+1)'(offset_o) - (OFS_W+1)'(prev_q);

  always_ff @(posedge clk_i) begin
    prev_q <= offset_o;
    if (rst_i || !en_i || centre_i) gap_q <= '0;
    else if (chg) gap_q <= CNT_W'(1);
    else if (gap_q != '1) gap_q <= gap_q + CNT_W'(1);
  end

  p_reset_idle_r1: assert property (@(posedge clk_i)
    ($past(rst_i) && !centre_i) |-> (offset_o == '0 && n_mod_o == n_base_i));

  p_restart_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    (!en_i ##1 (en_i && !centre_i)) |-> offset_o == '0);

  p_step_gap_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    (en_i && !centre_i && chg) |-> gap_q == need);

  p_unit_move_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    (en_i && $past(en_i) && !centre_i && !$past(centre_i)) |-> (move >= -1 && move <= 1));
endmodule

bind ssc_mod_ctrl ssc_mod_ctrl_chk #(
  .LIM_W(LIM_W), .PER_W(PER_W), .NDIV_W(NDIV_W), .TICK_DIV(TICK_DIV)
) u_chk (
  .clk_i(clk_i), .rst_i(rst_i), .en_i(en_i), .centre_i(centre_i),
  .step_per_i(step_per_i), .n_base_i(n_base_i),
  .offset_o(offset_o), .n_mod_o(n_mod_o)
);

// File: tb/tb_ssc_mod_ctrl.sv
`timescale 1ns/1ps
module tb_ssc_mod_ctrl;
  localparam int TD = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic en = 1'b0;
  logic centre = 1'b0;
  logic [3:0] up_lim = 4'd0;
  logic [3:0] dn_lim = 4'hB;
  logic [5:0] per = 6'd0;
  logic [10:0] n_base = 11'd890;
  logic signed [5:0] ofs;
  logic [10:0] n_mod;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ssc_mod_ctrl #(.LIM_W(4), .PER_W(6), .NDIV_W(11), .TICK_DIV(TD)) dut (
    .clk_i(clk), .rst_i(rst), .en_i(en), .centre_i(centre),
    .up_lim_i(up_lim), .dn_lim_i(dn_lim), .step_per_i(per),
    .n_base_i(n_base), .offset_o(ofs), .n_mod_o(n_mod)
  );

  typedef struct packed {
    logic [3:0]        up;
    logic [3:0]        dn;
    logic [5:0]        pr;
    logic              ctr;
    logic [7:0]        k;
    logic signed [5:0] ex;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{4'd0, 4'hB, 6'd0, 1'b0, 8'd3, -6'sd3},  // R5 descent
    '{4'd0, 4'hB, 6'd0, 1'b0, 8'd5, -6'sd5},  // R4 1011 -> -5
    '{4'd0, 4'hB, 6'd0, 1'b0, 8'd6, -6'sd4},  // R5 turn at floor
    '{4'd0, 4'hB, 6'd0, 1'b1, 8'd5, -6'sd3},  // R7 bias +2
    '{4'd3, 4'hE, 6'd1, 1'b0, 8'd2, -6'sd2},  // R3 period 1
    '{4'd3, 4'hE, 6'd1, 1'b0, 8'd7,  6'sd3},  // R5 reach top
    '{4'd3, 4'hE, 6'd1, 1'b0, 8'd8,  6'sd2},  // R5 turn at top
    '{4'd3, 4'hE, 6'd1, 1'b1, 8'd7,  6'sd2},  // R7 bias -1
    '{4'd3, 4'hE, 6'd1, 1'b1, 8'd2, -6'sd3},  // R7 bias -1 low side
    '{4'd0, 4'h8, 6'd0, 1'b0, 8'd8, -6'sd8},  // R4 1000 -> -8
    '{4'd0, 4'h8, 6'd0, 1'b0, 8'd9, -6'sd7},  // R4 R5 turn
    '{4'd0, 4'h8, 6'd0, 1'b1, 8'd8, -6'sd4},  // R7 bias +4
    '{4'd0, 4'h0, 6'd2, 1'b0, 8'd4,  6'sd0},  // R6 both zero
    '{4'd2, 4'h0, 6'd0, 1'b0, 8'd3,  6'sd1}   // R6 first step up
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic setup(input logic [3:0] u, input logic [3:0] d,
                       input logic [5:0] p, input logic c);
    @(negedge clk);
    en = 1'b0;
    up_lim = u; dn_lim = d; per = p; centre = c;
    @(negedge clk);
    en = 1'b1;
  endtask

  task automatic wait_edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 offset in reset", int'(ofs), 0);
    check("R1 n_mod in reset", int'(n_mod), 890);
    en = 1'b1;
    rst = 1'b0;
    wait_edges(1);
    check("R1 offset after reset", int'(ofs), 0);
    check("R1 n_mod after reset", int'(n_mod), 890);

    for (int i = 0; i < NV; i++) begin
      setup(VEC[i].up, VEC[i].dn, VEC[i].pr, VEC[i].ctr);
      wait_edges(int'(VEC[i].k) * (int'(VEC[i].pr) + 1) * TD);
      check($sformatf("R4 R5 R6 R7 vector %0d offset", i), int'(ofs), int'(VEC[i].ex));
      check($sformatf("R8 vector %0d n_mod", i), int'(n_mod), (890 + int'(VEC[i].ex)) % 2048);
    end

    // R3: step spacing (per=1 -> 4 cycles)
    setup(4'd3, 4'hE, 6'd1, 1'b0);
    wait_edges(3);
    check("R3 before first step", int'(ofs), 0);
    wait_edges(1);
    check("R3 at first step", int'(ofs), -1);
    wait_edges(3);
    check("R3 hold between steps", int'(ofs), -1);
    wait_edges(1);
    check("R3 at second step", int'(ofs), -2);

    // R2: disable clears, re-enable restarts downward
    setup(4'd0, 4'hB, 6'd0, 1'b0);
    wait_edges(3 * TD);
    check("R2 mid sweep", int'(ofs), -3);
    en = 1'b0;
    #0.5;
    check("R2 offset while disabled", int'(ofs), 0);
    wait_edges(2);
    check("R2 n_mod while disabled", int'(n_mod), 890);
    en = 1'b1;
    wait_edges(TD);
    check("R2 restart from zero downward", int'(ofs), -1);

    // R8: wrap below zero
    n_base = 11'd0;
    setup(4'd0, 4'hB, 6'd0, 1'b0);
    wait_edges(TD);
    check("R8 wrap modulo", int'(n_mod), 2047);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule